// File: doc/BRIEF.md
# Uptime Seconds and Sub-Second Counters

This block keeps two free-running timestamp counters, both driven by the 25 MHz reference clock that also clocks the block. The sub-second counter tracks reference cycles within the current second. It is coarse: it moves only once every sixteen cycles, adding sixteen each time. When it reaches one full second's worth of cycles it returns to zero, and on that same tick the seconds counter moves up by one. After a cold reset, the seconds counter therefore holds the number of whole seconds that have elapsed.

Software reads both values through a registered 32-bit read port, at byte offsets 0x68 (seconds) and 0x6C (sub-second), which sit among the clock-controller registers. The port keeps a pair of values consistent with each other. A read of the seconds word captures the sub-second value of that same cycle, and the sub-second read that follows returns this captured value. Writes that reach either counter have no effect.

Top module: `uptime_counters`

## Requirements
- R1: A synchronous reset (rst high) clears both counters to zero and discards any captured sub-second value.
- R2: The sub-second counter holds its value for TICK_DIV-1 cycles and then adds TICK_DIV. After n clock edges since reset it equals TICK_DIV*floor(n/TICK_DIV) modulo WRAP.
- R3: The four least significant bits of the sub-second value always read as zero (TICK_DIV = 16).
- R4: The sub-second counter never reads WRAP. The tick that would take it to WRAP takes it to zero instead (WRAP defaults to 25,000,000).
- R5: The seconds counter increments by one exactly on the tick that wraps the sub-second counter, and holds its value at all other times.
- R6: The seconds counter is SEC_W bits wide (32 by default) and wraps to zero after reaching its all-ones value.
- R7: A read with rd_en high returns data on rd_data, with rd_valid high, one cycle later. Byte address 0x68 returns the seconds value, 0x6C returns the sub-second value, and any other address returns zero. Both values are zero-extended to 32 bits.
- R8: A read of 0x68 captures the sub-second value of the same cycle. The next read of 0x6C returns that captured value and releases it. A 0x6C read that has no capture pending returns the live value.
- R9: Writes (wr_en with any wr_addr and wr_data) change neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high cold reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| wr_en | input | 1 | Write request (ignored) |
| wr_addr | input | ADDR_W | Byte address of the write (ignored) |
| wr_data | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds a read result |

## Verification
The bench keeps TICK_DIV at 16, so the step size and the zero low nibble are the same as in the default build. It shrinks WRAP to 160 and SEC_W to 4. With these values one "second" lasts 160 cycles and the seconds counter overflows after 2560 cycles. Sub-second rollover, the seconds increment and the seconds wrap all therefore occur within a short run.

// File: rtl/uptime_pkg.sv
package uptime_pkg;
  localparam int DATA_W = 32;
  localparam logic [11:0] OFS_SECONDS = 12'h068;
  localparam logic [11:0] OFS_SUBSEC  = 12'h06C;
endpackage

// File: rtl/uc_prescaler.sv
module uc_prescaler #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == LAST) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2: the tick never repeats on back-to-back cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/uc_subsec.sv
module uc_subsec #(
  parameter int TICK_DIV = 16,
  parameter int WRAP     = 25_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [31:0]     value,
  output logic            wrap_tick
);
  localparam int SW = $clog2(WRAP);
  localparam logic [SW-1:0] STEP   = SW'(TICK_DIV);
  localparam logic [SW-1:0] LASTV  = SW'(WRAP - TICK_DIV);

  logic [SW-1:0] count;

  assign wrap_tick = tick && (count == LASTV);

  always_ff @(posedge clk) begin
    if (rst)            count <= '0;
    else if (wrap_tick) count <= '0;
    else if (tick)      count <= count + STEP;
  end

  assign value = 32'(count);

  // R2: no movement between ticks
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  // R4: the value stays below the wrap point
  a_r4_below_wrap: assert property (@(posedge clk) disable iff (rst)
    32'(count) < 32'(WRAP));
  // R3: low nibble stays clear
  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    tick |=> value[3:0] == 4'h0);
endmodule

// File: rtl/uc_seconds.sv
module uc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [SEC_W-1:0] secs
);
  always_ff @(posedge clk) begin
    if (rst)      secs <= '0;
    else if (inc) secs <= secs + 1'b1;
  end

  // R5: one step per sub-second wrap, none otherwise
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> secs == SEC_W'($past(secs) + 1'b1));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(secs));
endmodule

// File: rtl/uc_readport.sv
module uc_readport #(
  parameter int ADDR_W = 12,
  parameter int SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEC_W-1:0]  secs,
  input  logic [31:0]       subsec,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  import uptime_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(OFS_SECONDS);
  localparam logic [ADDR_W-1:0] A_SUB = ADDR_W'(OFS_SUBSEC);

  logic [31:0] snap;
  logic        pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      snap     <= '0;
      pend     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (rd_addr == A_SEC) begin
          rd_data <= 32'(secs);
          snap    <= subsec;
          pend    <= 1'b1;
        end else if (rd_addr == A_SUB) begin
          rd_data <= pend ? snap : subsec;
          pend    <= 1'b0;
        end else begin
          rd_data <= '0;
        end
      end
    end
  end

  // R7: one-cycle read latency
  a_r7_valid_on: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r7_valid_off: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R8: a seconds read arms the capture
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_SEC) |=> (pend && snap == $past(subsec)));
endmodule

// File: rtl/uptime_counters.sv
module uptime_counters #(
  parameter int TICK_DIV = 16,
  parameter int WRAP     = 25_000_000,
  parameter int SEC_W    = 32,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  logic             tick;
  logic             wrap_tick;
  logic [31:0]      subsec;
  logic [SEC_W-1:0] secs;

  // Both counters are read-only: the write side is accepted and dropped.
  logic unused_wr;
  assign unused_wr = ^{wr_en, wr_addr, wr_data};

  uc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick));

  uc_subsec #(.TICK_DIV(TICK_DIV), .WRAP(WRAP)) u_sub (
    .clk(clk), .rst(rst), .tick(tick), .value(subsec), .wrap_tick(wrap_tick));

  uc_seconds #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .inc(wrap_tick), .secs(secs));

  uc_readport #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .secs(secs), .subsec(subsec), .rd_data(rd_data), .rd_valid(rd_valid));
endmodule

// File: tb/uptime_counters_bench.sv
module uptime_counters_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV  = 16;
  localparam int WRAPB = 160;
  localparam int SECW  = 4;
  localparam int AW    = 12;
  localparam logic [AW-1:0] A_SEC = 12'h068;
  localparam logic [AW-1:0] A_SUB = 12'h06C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int fails  = 0;
  int n = 0;
  bit pend = 1'b0;
  int snap = 0;
  bit done = 1'b0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) n <= rst ? 0 : n + 1;

  uptime_counters #(.TICK_DIV(TDIV), .WRAP(WRAPB), .SEC_W(SECW), .ADDR_W(AW))
    u_uptime_counters (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic int sub_at(input int m);
    return (TDIV * (m / TDIV)) % WRAPB;
  endfunction
  function automatic int sec_at(input int m);
    return (m / WRAPB) % (1 << SECW);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Issue a read at a negedge; returns data and the modelled expectation.
  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] e);
    int m;
    m = n;
    if (a == A_SEC) begin
      e = 32'(sec_at(m)); snap = sub_at(m); pend = 1'b1;
    end else if (a == A_SUB) begin
      e = pend ? 32'(snap) : 32'(sub_at(m)); pend = 1'b0;
    end else e = 32'h0;
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    check("R7 rd_valid", {31'h0, rd_valid}, 32'h1);
  endtask

  task automatic idle(input int g);
    for (int i = 0; i < g; i++) @(negedge clk);
  endtask

  localparam int VEC_N = 12;
  localparam logic [27:0] VEC [VEC_N] = '{
    {16'd5,   A_SUB}, {16'd11,  A_SUB}, {16'd140, A_SUB}, {16'd3,  A_SEC},
    {16'd40,  A_SUB}, {16'd0,   A_SUB}, {16'd300, A_SEC}, {16'd1,  A_SEC},
    {16'd77,  A_SUB}, {16'd9,   12'h070}, {16'd150, A_SEC}, {16'd2, A_SUB}};

  initial begin
    logic [31:0] exp;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    do_read(A_SEC, got, exp); check("R1 seconds after reset", got, 32'h0);
    do_read(A_SUB, got, exp); check("R1 subsec after reset", got, 32'h0);

    // Vector walk: R2, R4, R5, R7, R8
    for (int v = 0; v < VEC_N; v++) begin
      idle(int'(VEC[v][27:12]));
      do_read(VEC[v][11:0], got, exp);
      check("R2/R5/R7/R8 vector", got, exp);
      if (VEC[v][11:0] == A_SUB) check("R3 low nibble", {28'h0, got[3:0]}, 32'h0);
    end

    // R4: read just before and right after a rollover
    while ((n % WRAPB) != WRAPB - 1) @(negedge clk);
    do_read(A_SUB, got, exp); check("R4 last step before wrap", got, 32'(WRAPB - TDIV));
    do_read(A_SUB, got, exp); check("R4 wrapped to zero", got, 32'h0);

    // R8: captured value survives an intervening wait
    idle(20);
    do_read(A_SEC, got, exp); check("R8 seconds", got, exp);
    idle(33);
    do_read(A_SUB, got, exp); check("R8 captured subsec", got, exp);
    do_read(A_SUB, got, exp); check("R8 live after release", got, exp);

    // R9: writes to both counters are dropped
    wr_en = 1'b1; wr_addr = A_SUB; wr_data = 32'hFFFF_FFF0;
    @(negedge clk);
    wr_addr = A_SEC; wr_data = 32'h0000_000A;
    @(negedge clk);
    wr_en = 1'b0;
    do_read(A_SUB, got, exp); check("R9 subsec unaffected", got, exp);
    do_read(A_SEC, got, exp); check("R9 seconds unaffected", got, exp);
    do_read(A_SUB, got, exp);

    // R6: seconds wrap after 2^SECW seconds
    while (n < WRAPB * (1 << SECW) + 5) @(negedge clk);
    do_read(A_SEC, got, exp); check("R6 seconds wrapped", got, 32'h0);
    do_read(A_SUB, got, exp);

    // R1: mid-run reset discards counts and capture
    idle(50);
    do_read(A_SEC, got, exp);
    rst = 1'b1; pend = 1'b0;
    idle(2);
    rst = 1'b0;
    idle(20);
    do_read(A_SUB, got, exp); check("R1 capture dropped by reset", got, 32'(sub_at(20)));
    do_read(A_SEC, got, exp); check("R1 seconds after re-reset", got, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule